// File: doc/BRIEF.md
# Two-Master Hardware Semaphore Bank

This block holds a bank of hardware semaphores that two bus masters use to share resources without a software lock protocol. Master A is the application processor and master B is the network processor. Each semaphore is a 2-bit owner field. Either master claims a free field by writing its own code. A field that is held accepts nothing but a release, and either master may write that release. Three peripheral semaphores cover two serial-bus controllers and the flash controller. One multi-field register arbitrates five shared GPIO pins, and each pin has its own 2-bit field. Twelve general-purpose semaphores complete the bank.

Each master has its own write port, so both can write in the same cycle. A combinational read port returns three kinds of register: the semaphore registers, two packed status words that mirror the current owners, and previous-owner words. The previous-owner words record what each semaphore held before its last real change. The `owner_o` vector drives every field's owner directly to the resource muxes outside this block.

The register map is as follows:
- Serial bus 0 semaphore: address 0.
- Serial bus 1 semaphore: address 1.
- Flash semaphore: address 2.
- GPIO register: address 3.
- General semaphores 0..11: addresses 4..15.
- Peripheral status word: address 16.
- General status word: address 17.
- Previous-owner words: addresses 18 and 19.

Every field has a flat index:
- Index 0: serial bus 0.
- Index 1: serial bus 1.
- Index 2: flash.
- Indices 3..7: GPIO fields 0..4.
- Indices 8..19: general semaphores 0..11.

Field i sits at `owner_o[2i+1:2i]`. It also sits in the previous-owner space at bits [2i+1:2i] of the concatenation {word at 19, word at 18}.

Top module: `sema_bank`

## Requirements
- R1: Owner codes are 00 free, 01 master A and 10 master B. A write of 01 or 10 to a free field takes it on the next clock edge. That code is then read back and appears on the field's `owner_o` slot. No field ever holds 11.
- R2: While a field is nonzero, a write of 00 from either master releases it. Any other code written to that field by either master is ignored.
- R3: A field code of 11 leaves that field unchanged, in any register. The GPIO register at address 3 packs fields 0..4 at bits [1:0], [3:2], [5:4], [7:6] and [9:8], and each field is arbitrated on its own. For example, 0x3FB claims field 1 for master B and 0x3F3 releases field 1.
- R4: When both masters write a code other than 11 to the same field in the same cycle, master A's code is applied and master B's code is dropped. A field that master A writes as 11 takes master B's code.
- R5: The peripheral status word at address 16 shows serial bus 0 at [1:0], serial bus 1 at [5:4], GPIO field 0 at [7:6] and flash at [9:8]. All other bits are 0.
- R6: The general status word at address 17 shows general semaphore g at bits [2g+1:2g] for g = 0..10. The last general semaphore is not mirrored, so bits [23:22] and all bits above them read 0.
- R7: A field's previous-owner slot takes the field's old value in the same edge that changes the field. A write that leaves the field unchanged leaves the slot unchanged.
- R8: After reset, every field, every status bit and every previous-owner slot reads 00.
- R9: A semaphore register reads back its field or fields, with all other bits 0. Writes to the status addresses, to the previous-owner addresses or to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_a | input | 1 | Master A write strobe |
| wr_addr_a | input | 5 | Master A write address |
| wr_data_a | input | 32 | Master A write data |
| wr_en_b | input | 1 | Master B write strobe |
| wr_addr_b | input | 5 | Master B write address |
| wr_data_b | input | 32 | Master B write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| owner_o | output | 40 | Current owner of each field, 2 bits per flat index |

## Verification
The bench builds the block with its defaults: five GPIO fields, twelve general semaphores and 32-bit data. With twenty fields, the previous-owner slots spill from the first word into the second. The last general semaphore therefore lands in the second word, which lets the bench check that word's slot offset. With twelve general semaphores, the bench can also show that the slot of the last one is missing from the general status word while that semaphore itself still locks. Five GPIO fields make the whole 10-bit mask pattern available, so the bench can check one field's claim and release while its neighbours are held.

// File: rtl/sema_pkg.sv
package sema_pkg;

  localparam logic [1:0] OWN_FREE = 2'b00;
  localparam logic [1:0] OWN_A    = 2'b01;
  localparam logic [1:0] OWN_B    = 2'b10;
  localparam logic [1:0] OWN_KEEP = 2'b11;

  localparam int N_PERIPH  = 3;
  localparam int GPIO_ADDR = 3;
  localparam int GEN_BASE  = 4;

  // Next owner of one field, given the winning write code.
  function automatic logic [1:0] sem_next(logic [1:0] cur, logic hit, logic [1:0] code);
    if (!hit || code == OWN_KEEP) return cur;
    if (cur == OWN_FREE) return code;
    return (code == OWN_FREE) ? OWN_FREE : cur;
  endfunction

  // Register address that holds flat field i.
  function automatic int sem_reg(int i, int ngpio);
    if (i < N_PERIPH) return i;
    if (i < N_PERIPH + ngpio) return GPIO_ADDR;
    return GEN_BASE + (i - N_PERIPH - ngpio);
  endfunction

  // Bit position of flat field i inside its register.
  function automatic int sem_lsb(int i, int ngpio);
    if (i >= N_PERIPH && i < N_PERIPH + ngpio) return 2 * (i - N_PERIPH);
    return 0;
  endfunction

endpackage

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_hit,
  input  logic [1:0] a_code,
  input  logic       b_hit,
  input  logic [1:0] b_code,
  output logic [1:0] owner,
  output logic [1:0] prev
);

  logic [1:0] own_q, prev_q, sel_code, nxt;
  logic       sel_hit, chg;

  always_comb begin
    sel_hit  = a_hit | b_hit;
    sel_code = a_hit ? a_code : b_code;
    nxt      = sem_next(own_q, sel_hit, sel_code);
    chg      = (nxt != own_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= OWN_FREE;
      prev_q <= OWN_FREE;
    end else if (chg) begin
      prev_q <= own_q;
      own_q  <= nxt;
    end
  end

  assign owner = own_q;
  assign prev  = prev_q;

  AST_NEVER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    own_q != OWN_KEEP); // R1
  AST_HELD_RELEASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q != OWN_FREE) |=> (own_q == $past(own_q) || own_q == OWN_FREE)); // R2
  AST_A_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_FREE && a_hit && b_hit) |=> (own_q == $past(a_code))); // R4
  AST_PREV_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (prev_q == $past(own_q))); // R7
  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |=> $stable(prev_q)); // R7

endmodule

// File: rtl/sema_status.sv
module sema_status
  import sema_pkg::*;
#(
  parameter int NGEN   = 12,
  parameter int NGPIO  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int NSEM    = N_PERIPH + NGPIO + NGEN,
  localparam int NPREV   = (2 * NSEM + DATA_W - 1) / DATA_W,
  localparam int GEN_FLT = N_PERIPH + NGPIO,
  localparam int STAT_P  = GEN_BASE + NGEN,
  localparam int STAT_G  = STAT_P + 1,
  localparam int PREV_B  = STAT_G + 1
) (
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [2*NSEM-1:0]   owner,
  input  logic [2*NSEM-1:0]   prev,
  output logic [DATA_W-1:0]   rd_data
);

  logic [NPREV*DATA_W-1:0] prev_pad;

  always_comb begin
    prev_pad = '0;
    prev_pad[2*NSEM-1:0] = prev;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSEM; i++) begin
      if (rd_addr == ADDR_W'(sem_reg(i, NGPIO)))
        rd_data[sem_lsb(i, NGPIO) +: 2] = owner[2*i +: 2];
    end
    if (rd_addr == ADDR_W'(STAT_P)) begin
      rd_data[1:0] = owner[1:0];
      rd_data[5:4] = owner[3:2];
      rd_data[7:6] = owner[2*N_PERIPH +: 2];
      rd_data[9:8] = owner[5:4];
    end
    if (rd_addr == ADDR_W'(STAT_G)) begin
      for (int g = 0; g < NGEN - 1; g++)
        rd_data[2*g +: 2] = owner[2*(GEN_FLT + g) +: 2];
    end
    for (int k = 0; k < NPREV; k++) begin
      if (rd_addr == ADDR_W'(PREV_B + k))
        rd_data = prev_pad[k*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int NGEN   = 12,
  parameter int NGPIO  = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int NSEM  = N_PERIPH + NGPIO + NGEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_a,
  input  logic [ADDR_W-1:0] wr_addr_a,
  input  logic [DATA_W-1:0] wr_data_a,
  input  logic              wr_en_b,
  input  logic [ADDR_W-1:0] wr_addr_b,
  input  logic [DATA_W-1:0] wr_data_b,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [2*NSEM-1:0] owner_o
);

  logic [2*NSEM-1:0] own_flat, prev_flat;
  logic              unused_wr;

  assign unused_wr = ^{wr_data_a, wr_data_b};

  for (genvar i = 0; i < NSEM; i++) begin : g_sem
    localparam int REG = sem_reg(i, NGPIO);
    localparam int LSB = sem_lsb(i, NGPIO);
    logic [1:0] fa, fb;
    logic       ha, hb;

    assign fa = wr_data_a[LSB +: 2];
    assign fb = wr_data_b[LSB +: 2];
    assign ha = wr_en_a && (wr_addr_a == ADDR_W'(REG)) && (fa != OWN_KEEP);
    assign hb = wr_en_b && (wr_addr_b == ADDR_W'(REG)) && (fb != OWN_KEEP);

    sema_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .a_hit  (ha),
      .a_code (fa),
      .b_hit  (hb),
      .b_code (fb),
      .owner  (own_flat[2*i +: 2]),
      .prev   (prev_flat[2*i +: 2])
    );
  end

  sema_status #(
    .NGEN   (NGEN),
    .NGPIO  (NGPIO),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_status (
    .rd_addr (rd_addr),
    .owner   (own_flat),
    .prev    (prev_flat),
    .rd_data (rd_data)
  );

  assign owner_o = own_flat;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (own_flat == '0 && prev_flat == '0)); // R8

endmodule

// File: tb/test_sema_bank.sv
module test_sema_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [4:0]  wr_addr_a = '0, wr_addr_b = '0, rd_addr = '0;
  logic [31:0] wr_data_a = '0, wr_data_b = '0;
  logic [31:0] rd_data;
  logic [39:0] owner_o;
  int total = 0;
  int bad = 0;

  localparam logic [4:0] P0 = 5'd0, P1 = 5'd1, FL = 5'd2, GP = 5'd3;
  localparam logic [4:0] SP = 5'd16, SG = 5'd17, PV0 = 5'd18, PV1 = 5'd19;

  always #4 clk = ~clk;

  sema_bank i_sema_bank (
    .clk (clk), .rst_n (rst_n),
    .wr_en_a (wr_en_a), .wr_addr_a (wr_addr_a), .wr_data_a (wr_data_a),
    .wr_en_b (wr_en_b), .wr_addr_b (wr_addr_b), .wr_data_b (wr_data_b),
    .rd_addr (rd_addr), .rd_data (rd_data), .owner_o (owner_o)
  );

  function automatic logic [4:0] gen(int g);
    return 5'(4 + g);
  endfunction

  task automatic put(input logic ea, input logic [4:0] aa, input logic [31:0] da,
                     input logic eb, input logic [4:0] ab, input logic [31:0] db);
    @(negedge clk);
    wr_en_a = ea; wr_addr_a = aa; wr_data_a = da;
    wr_en_b = eb; wr_addr_b = ab; wr_data_b = db;
    @(negedge clk);
    wr_en_a = 1'b0; wr_en_b = 1'b0;
  endtask

  task automatic put_a(input logic [4:0] a, input logic [31:0] d);
    put(1'b1, a, d, 1'b0, '0, '0);
  endtask

  task automatic put_b(input logic [4:0] a, input logic [31:0] d);
    put(1'b0, '0, '0, 1'b1, a, d);
  endtask

  task automatic chk(input logic [4:0] a, input logic [31:0] mask, input logic [31:0] exp,
                     input string tag);
    rd_addr = a;
    #1;
    total++;
    if ((rd_data & mask) !== exp) begin
      bad++;
      $display("FAIL %s: addr %0d actual %h expected %h", tag, a, rd_data & mask, exp);
    end
  endtask

  task automatic chk_own(input int idx, input logic [1:0] exp, input string tag);
    total++;
    if (owner_o[2*idx +: 2] !== exp) begin
      bad++;
      $display("FAIL %s: owner slot %0d actual %b expected %b", tag, idx, owner_o[2*idx +: 2], exp);
    end
  endtask

  task automatic t_reset;
    for (int a = 0; a < 20; a++) chk(5'(a), '1, '0, "R8 reset read");
    total++;
    if (owner_o !== '0) begin
      bad++;
      $display("FAIL R8: owner_o actual %h expected 0", owner_o);
    end
  endtask

  task automatic t_grant;
    put_a(P0, 32'h1);
    chk(P0, '1, 32'h1, "R1 A grant");
    chk_own(0, 2'b01, "R1 A owner");
    put_b(P1, 32'h2);
    chk(P1, '1, 32'h2, "R1 B grant");
    chk_own(1, 2'b10, "R1 B owner");
    chk(FL, '1, 32'h0, "R1 untouched");
  endtask

  task automatic t_held;
    put_b(P0, 32'h2);
    chk(P0, '1, 32'h1, "R2 B claim on held");
    put_a(P0, 32'h2);
    chk(P0, '1, 32'h1, "R2 other code on held");
    chk(PV0, 32'h3, 32'h0, "R7 no change keeps prev");
    put_b(P0, 32'h0);
    chk(P0, '1, 32'h0, "R2 release by B");
    chk(PV0, 32'h3, 32'h1, "R7 prev after release");
  endtask

  task automatic t_gpio;
    put_b(GP, 32'h3FB);
    chk(GP, '1, 32'h008, "R3 mask claim field1");
    chk_own(4, 2'b10, "R3 field1 owner");
    put_a(GP, 32'h3FD);
    chk(GP, '1, 32'h009, "R3 independent field0");
    put_b(GP, 32'h3FF);
    chk(GP, '1, 32'h009, "R3 all-keep write");
    put_a(GP, 32'h3F3);
    chk(GP, '1, 32'h001, "R3 mask release field1");
    chk(PV0, 32'h300, 32'h200, "R7 gpio field1 prev");
    put_a(gen(0), 32'h3);
    chk(gen(0), '1, 32'h0, "R3 keep on free field");
  endtask

  task automatic t_conflict;
    put(1'b1, gen(0), 32'h1, 1'b1, gen(0), 32'h2);
    chk(gen(0), '1, 32'h1, "R4 A wins free field");
    put(1'b1, gen(0), 32'h2, 1'b1, gen(0), 32'h0);
    chk(gen(0), '1, 32'h1, "R4 B release dropped");
    put(1'b1, GP, 32'h3FF, 1'b1, GP, 32'h3EF);
    chk(GP, '1, 32'h021, "R4 A keep lets B in");
  endtask

  task automatic t_stat;
    put_b(P0, 32'h2);
    put_a(FL, 32'h1);
    chk(SP, '1, 32'h162, "R5 peripheral status");
  endtask

  task automatic t_gen;
    put_b(gen(5), 32'h2);
    put_a(gen(11), 32'h1);
    chk(SG, '1, 32'h801, "R6 general status");
    chk(gen(11), '1, 32'h1, "R6 last general held");
    chk_own(19, 2'b01, "R6 last general owner");
  endtask

  task automatic t_prev;
    chk(PV0, 32'h3 << 16, 32'h0, "R7 gen0 prev after grant");
    put_b(gen(0), 32'h0);
    chk(PV0, 32'h3 << 16, 32'h1 << 16, "R7 gen0 prev after release");
    put_b(gen(11), 32'h2);
    chk(PV1, 32'hC0, 32'h0, "R7 ignored keeps prev");
    put_a(gen(11), 32'h0);
    chk(PV1, 32'hC0, 32'h40, "R7 second word slot");
    chk(gen(11), '1, 32'h0, "R2 release gen11");
  endtask

  task automatic t_readonly;
    logic [31:0] snap [20];
    for (int a = 0; a < 20; a++) begin
      rd_addr = 5'(a);
      #1;
      snap[a] = rd_data;
    end
    put(1'b1, SP, '1, 1'b1, SG, '1);
    put(1'b1, PV0, '1, 1'b1, PV1, '1);
    put(1'b1, 5'd31, '1, 1'b1, 5'd25, '1);
    for (int a = 0; a < 20; a++) chk(5'(a), '1, snap[a], "R9 read-only writes");
    chk(GP, '1, 32'h021, "R9 gpio readback");
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_grant;
    t_held;
    t_gpio;
    t_conflict;
    t_stat;
    t_gen;
    t_prev;
    t_readonly;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule